// File: doc/BRIEF.md
# Fast Context Switch Address Remapper

This block sits between a processor core's address outputs and the caches and MMU. It holds a small process identifier and uses it to relocate every address in the lowest 32 MB window into a separate 32 MB slot for each process. Each process's low addresses therefore become distinct modified virtual addresses, and switching processes needs no flush of caches or TLBs. Addresses outside the window pass through unchanged.

There are two address paths. The data path takes a new identifier on the cycle after a register write. The instruction-fetch path keeps the old identifier for the next two counted fetches, which stand for instructions that were already in flight. Relocation is off when the MMU is disabled. It is also off for data-side accesses that are flagged as entry-based cache or TLB maintenance. Translation is combinational, so neither path adds a cycle.

Top module: `ctx_remap`

## Requirements
- R1: After reset the identifier is 0, a register read returns 0x0000_0000, and both paths output their input address unchanged.
- R2: A register write stores bits 31:25 of the write word as the identifier and ignores bits 24:0. A read returns the identifier in bits 31:25 and zeros in bits 24:0.
- R3: With the MMU enabled and no maintenance flag, an address whose bits 31:25 are all zero leaves with bits 31:25 replaced by the effective identifier and bits 24:0 unchanged. This equals address + ID × 32 MB.
- R4: An address at or above 0x0200_0000 leaves unchanged on both paths.
- R5: With an effective identifier of 0 the output equals the input for every address.
- R6: While the MMU-enable input is low, both outputs equal their inputs.
- R7: A data access with the maintenance flag high is never relocated.
- R8: After a write, the first two fetch-valid cycles that follow the write cycle still use the old identifier, and the third such fetch onward uses the new one. Cycles with fetch-valid low do not count. A fetch in the write cycle itself uses the old identifier and is not counted.
- R9: The data path and register reads use the new identifier from the cycle after the write.
- R10: A second write while the fetch path is still waiting restarts the two-fetch wait. The fetch path then commits the latest written identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the identifier register |
| reg_wr_data | input | 32 | Write word, identifier in bits 31:25 |
| reg_rd_data | output | 32 | Read word, identifier in bits 31:25 |
| mmu_en | input | 1 | MMU enable; low disables relocation |
| fetch_valid | input | 1 | A fetch is issued this cycle |
| fetch_va | input | 32 | Fetch virtual address |
| fetch_mva | output | 32 | Fetch modified virtual address |
| data_va | input | 32 | Data virtual address |
| data_maint | input | 1 | Access is an entry-based cache/TLB maintenance operation |
| data_mva | output | 32 | Data modified virtual address |

## Verification
The bench steps through the window boundary at 0x01FF_FFFF and 0x0200_0000. A design with an off-by-one window check would relocate the first of these wrongly or move the second. Fetch-lag tests mix idle cycles between fetches, issue a fetch in the write cycle, and rewrite the identifier mid-wait. A design that counted plain cycles, counted the write-cycle fetch, or failed to restart would switch the fetch stream one fetch early or commit a stale identifier. Bypass tests flip the MMU enable and the maintenance flag with a non-zero identifier loaded, so a missing bypass shows up as a relocated address.

// File: rtl/ctx_remap_pkg.sv
package ctx_remap_pkg;
    localparam int unsigned ADDR_W_DEF    = 32;
    localparam int unsigned ID_W_DEF      = 7;
    localparam int unsigned FETCH_LAG_DEF = 2;

    // true when the address lies inside the relocatable low window
    function automatic logic in_low_window(input logic [ADDR_W_DEF-1:0] va,
                                           input int unsigned id_w);
        logic hit;
        hit = 1'b1;
        for (int i = 0; i < ADDR_W_DEF; i++) begin
            if (i >= ADDR_W_DEF - id_w && va[i]) hit = 1'b0;
        end
        return hit;
    endfunction
endpackage

// File: rtl/ctx_id_state.sv
module ctx_id_state #(
    parameter int unsigned ID_W      = 7,
    parameter int unsigned FETCH_LAG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic            fetch_valid,
    output logic [ID_W-1:0] data_id,
    output logic [ID_W-1:0] fetch_id
);
    localparam int unsigned CNT_W = (FETCH_LAG < 1) ? 1 : $clog2(FETCH_LAG + 1);

    typedef struct packed {
        logic [ID_W-1:0]  arch_id;
        logic [ID_W-1:0]  fetch_id;
        logic             pending;
        logic [CNT_W-1:0] cnt;
    } id_state_t;

    id_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fetch_valid && st_q.pending && !wr_en) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.fetch_id = st_q.arch_id;
                st_d.pending  = 1'b0;
                st_d.cnt      = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (wr_en) begin
            st_d.arch_id = wr_id;
            if (FETCH_LAG == 0) begin
                st_d.fetch_id = wr_id;
                st_d.pending  = 1'b0;
                st_d.cnt      = '0;
            end else begin
                st_d.pending = 1'b1;
                st_d.cnt     = CNT_W'(FETCH_LAG);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_id  = st_q.arch_id;
    assign fetch_id = st_q.fetch_id;

    // R9: data side follows the write on the next cycle
    a_r9_data_next: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_id == $past(wr_id));
    // R8: a write never moves the fetch identifier on the next cycle
    a_r8_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && FETCH_LAG > 0) |=> fetch_id == $past(fetch_id));
    // R8: without a fetch the fetch identifier never changes
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !wr_en) |=> $stable(fetch_id));
endmodule

// File: rtl/ctx_addr_xlate.sv
module ctx_addr_xlate #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ID_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] va,
    input  logic [ID_W-1:0]   id,
    input  logic              relocate_en,
    output logic [ADDR_W-1:0] mva
);
    localparam int unsigned OFF_W = ADDR_W - ID_W;

    logic low_hit;

    always_comb begin
        low_hit = (va[ADDR_W-1:OFF_W] == '0);
        mva     = va;
        if (relocate_en && low_hit) mva = {id, va[OFF_W-1:0]};
    end

    // R4: addresses above the window leave untouched
    a_r4_high_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (va >= (ADDR_W'(1) << OFF_W)) |-> mva == va);
    // R6/R7: disabled relocation is an identity
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !relocate_en |-> mva == va);
    // R3: window addresses keep their offset and take the identifier
    a_r3_low_relocate: assert property (@(posedge clk) disable iff (!rst_n)
        (relocate_en && va < (ADDR_W'(1) << OFF_W)) |->
        (mva[OFF_W-1:0] == va[OFF_W-1:0] && mva[ADDR_W-1:OFF_W] == id));
endmodule

// File: rtl/ctx_remap.sv
module ctx_remap
    import ctx_remap_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_W_DEF,
    parameter int unsigned ID_W      = ID_W_DEF,
    parameter int unsigned FETCH_LAG = FETCH_LAG_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_data,
    input  logic              mmu_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_va,
    output logic [ADDR_W-1:0] fetch_mva,
    input  logic [ADDR_W-1:0] data_va,
    input  logic              data_maint,
    output logic [ADDR_W-1:0] data_mva
);
    localparam int unsigned OFF_W = ADDR_W - ID_W;

    logic [ID_W-1:0] data_id, fetch_id;
    logic            sbz_unused;

    assign sbz_unused = ^reg_wr_data[OFF_W-1:0];

    ctx_id_state #(.ID_W(ID_W), .FETCH_LAG(FETCH_LAG)) u_state (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_id(reg_wr_data[ADDR_W-1:OFF_W]),
        .fetch_valid(fetch_valid),
        .data_id(data_id), .fetch_id(fetch_id)
    );

    ctx_addr_xlate #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_fetch_xlate (
        .clk(clk), .rst_n(rst_n), .va(fetch_va), .id(fetch_id),
        .relocate_en(mmu_en), .mva(fetch_mva)
    );

    ctx_addr_xlate #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_data_xlate (
        .clk(clk), .rst_n(rst_n), .va(data_va), .id(data_id),
        .relocate_en(mmu_en && !data_maint), .mva(data_mva)
    );

    assign reg_rd_data = {data_id, {OFF_W{1'b0}}};

    // R7: maintenance accesses are never moved
    a_r7_maint_flat: assert property (@(posedge clk) disable iff (!rst_n)
        data_maint |-> data_mva == data_va);
    // R6: MMU off keeps the fetch path flat
    a_r6_mmu_off_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !mmu_en |-> fetch_mva == fetch_va);
endmodule

// File: tb/ctx_remap_bench.sv
module ctx_remap_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data, reg_rd_data;
    logic        mmu_en, fetch_valid, data_maint;
    logic [31:0] fetch_va, fetch_mva, data_va, data_mva;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    ctx_remap u_ctx_remap (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .mmu_en(mmu_en), .fetch_valid(fetch_valid),
        .fetch_va(fetch_va), .fetch_mva(fetch_mva), .data_va(data_va),
        .data_maint(data_maint), .data_mva(data_mva)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr_id(input logic [31:0] w);
        @(negedge clk);
        fetch_valid = 1'b0;
        reg_wr_en = 1'b1; reg_wr_data = w;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] va, input logic [31:0] exp, input string req);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_va = va;
        #1 chk(req, fetch_mva, exp);
    endtask

    task automatic idle();
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic data_chk(input logic [31:0] va, input logic m, input logic [31:0] exp,
                            input string req);
        data_va = va; data_maint = m;
        #1 chk(req, data_mva, exp);
    endtask

    task automatic t_reset();
        chk("R1 read", reg_rd_data, 32'h0);
        data_chk(32'h0123_4567, 1'b0, 32'h0123_4567, "R1 data");
        fetch_va = 32'h0000_1000; #1 chk("R1 fetch", fetch_mva, 32'h0000_1000);
    endtask

    task automatic t_reg_word();
        wr_id(32'hFFFF_FFFF);
        chk("R2 sbz read", reg_rd_data, 32'hFE00_0000);
        wr_id(32'h0A01_FFFF);
        chk("R2 id5 read", reg_rd_data, 32'h0A00_0000);
    endtask

    task automatic t_data_map();
        // id 5 from previous write; data takes it the cycle after (R9)
        data_chk(32'h0123_4567, 1'b0, 32'h0B23_4567, "R3 R9 data");
        data_chk(32'h01FF_FFFF, 1'b0, 32'h0BFF_FFFF, "R3 top of window");
        data_chk(32'h0200_0000, 1'b0, 32'h0200_0000, "R4 window edge");
        data_chk(32'hFFFF_0000, 1'b0, 32'hFFFF_0000, "R4 high");
        data_chk(32'h0000_0040, 1'b1, 32'h0000_0040, "R7 maint");
        mmu_en = 1'b0;
        data_chk(32'h0000_0040, 1'b0, 32'h0000_0040, "R6 data mmu off");
        fetch_va = 32'h0000_0080; #1 chk("R6 fetch mmu off", fetch_mva, 32'h0000_0080);
        mmu_en = 1'b1;
    endtask

    task automatic t_fetch_lag();
        // fetch id is 5 after enough fetches; drain pending first
        fetch(32'h0, 32'h0, "R8 drain1");
        fetch(32'h0, 32'h0, "R8 drain2");
        fetch(32'h100, 32'h0A00_0100, "R8 settled id5");
        wr_id(32'h0600_0000); // id 3
        idle();
        fetch(32'h100, 32'h0A00_0100, "R8 first old");
        idle();
        fetch(32'h104, 32'h0A00_0104, "R8 second old");
        fetch(32'h108, 32'h0600_0108, "R8 third new");
        fetch(32'h0300_0000, 32'h0300_0000, "R4 fetch high");
    endtask

    task automatic t_write_cycle_fetch();
        // fetch in the write cycle is not counted
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 32'h0200_0000; // id 1
        fetch_valid = 1'b1; fetch_va = 32'h10;
        #1 chk("R8 write-cycle fetch", fetch_mva, 32'h0600_0010);
        @(negedge clk); reg_wr_en = 1'b0;
        #1 chk("R8 after wr 1st old", fetch_mva, 32'h0600_0010);
        fetch(32'h14, 32'h0600_0014, "R8 after wr 2nd old");
        fetch(32'h18, 32'h0200_0018, "R8 after wr 3rd new");
    endtask

    task automatic t_restart();
        wr_id(32'h0400_0000); // id 2
        fetch(32'h20, 32'h0200_0020, "R10 old a");
        wr_id(32'h0E00_0000); // id 7 restarts
        fetch(32'h24, 32'h0200_0024, "R10 old b");
        fetch(32'h28, 32'h0200_0028, "R10 old c");
        fetch(32'h2C, 32'h0E00_002C, "R10 latest");
        wr_id(32'h0000_0000);
        data_chk(32'h0123_4567, 1'b0, 32'h0123_4567, "R5 id0 data flat");
        fetch(32'h30, 32'h0E00_0030, "R8 id0 old");
        fetch(32'h34, 32'h0E00_0034, "R8 id0 old2");
        fetch(32'h0123_0000, 32'h0123_0000, "R5 id0 fetch flat");
        idle();
    endtask

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0; mmu_en = 1'b1;
        fetch_valid = 1'b0; fetch_va = '0; data_va = '0; data_maint = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_word();
        t_data_map();
        t_fetch_lag();
        t_write_cycle_fetch();
        t_restart();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule